// File: doc/BRIEF.md
# Periodic Down-Counter Timer with Compare

A register-mapped timer built on a down-counter (32 bits by default). Software picks one of three tick-enable inputs as the count source, divides it by a 12-bit prescale value plus one, and lets the counter either reload from a programmable load value or wrap freely from all ones each time it passes zero. A compare register sets a sticky status flag whenever a count step lands on the compare value, and that flag, gated by an interrupt enable and the timer enable, drives a level interrupt.

Software reaches five word registers through a simple port with write and read strobes. Read data is registered and appears on `rdata` in the cycle after `rd_en`. A small two-state machine tracks whether the counter runs: HALT (counter frozen) and COUNT (counter steps on every prescaled tick). The transition ARM moves HALT to COUNT once the enable bit is set. The transition STOP moves COUNT back to HALT when the enable bit is cleared. Stop, doze, wait and debug-freeze control bits are stored and read back but have no effect on counting.

Top module: `dt_timer_top`

## Requirements
- R1: After reset, control reads 0, status reads 0, load reads all ones, compare reads 0, the count reads all ones, and `irq` is low.
- R2: Word addresses are 0 control, 1 status, 2 load, 3 compare and 4 count. Count is read-only, and addresses 5 to 7 read 0. Read data appears one cycle after `rd_en`. Control keeps only bits 25:0, so bits 31:26 and the self-clearing software-reset bit 16 read as 0.
- R3: The control source field at bits 25:24 picks the count source: 00 none, 01 `tick_main`, 10 `tick_fast`, 11 `tick_slow`. Ticks on unselected inputs have no effect on the count.
- R4: With the prescale field at bits 15:4 holding P, the counter steps once for every P+1 ticks of the selected source.
- R5: With reload mode (control bit 3) set, a step from 0 loads the load value. Any other step decrements by one.
- R6: With reload mode clear, a step from 0 wraps to all ones.
- R7: A write that sets enable (bit 0) while it was clear, with enable-mode (bit 1) set, loads the counter with the load value in reload mode and with all ones otherwise. Without enable-mode, counting resumes from the held value.
- R8: A load write with overwrite (bit 17) set forces the counter to the written value at once. Without overwrite, the counter is untouched and the new value is used at the next reload.
- R9: A count step whose result equals the compare value sets status bit 0. The bit stays set until a status write with bit 0 at 1. A status write with bit 0 at 0 has no effect.
- R10: `irq` is high exactly when the status flag, compare-interrupt enable (bit 2) and enable (bit 0) are all set.
- R11: While enable is clear, the count holds its value whatever ticks arrive.
- R12: A control write with bit 16 set keeps only the written enable, enable-mode and bits 21:18 (stop, doze, wait, debug), and clears the rest of control. It also clears status and compare, sets load to all ones and sets the count to all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tick_main | input | 1 | Main peripheral tick enable (source 01) |
| tick_fast | input | 1 | High-frequency tick enable (source 10) |
| tick_slow | input | 1 | Slow ~32 kHz tick enable (source 11) |
| irq | output | 1 | Level compare interrupt |

## Verification
On every cycle, the assertions check that the count is frozen while the timer is disabled and no write arrives. They also check that, without a write, the count only ever holds, decrements by one, or leaves zero for the load value or for all ones as the mode requires. Finally, they check that the compare flag stays set until software acts and that the interrupt is low while the timer is disabled. Only the bench scenarios can show the arithmetic of the prescale divide, the choice of tick source, the exact loads on enable and on overwrite, the delayed use of a new load value, and the fields kept by a software reset. The bench sweeps these with expected counts computed from the tick sequence it drives.

// File: rtl/dt_pkg.sv
`timescale 1ns/1ps
package dt_pkg;
    localparam int CTRL_W   = 26;
    localparam int PRE_W    = 12;
    localparam int B_EN     = 0;
    localparam int B_ENMOD  = 1;
    localparam int B_OCIE   = 2;
    localparam int B_RLD    = 3;
    localparam int B_PRE_LO = 4;
    localparam int B_PRE_HI = B_PRE_LO + PRE_W - 1;
    localparam int B_SWR    = 16;
    localparam int B_OVW    = 17;
    localparam int B_SRC_LO = 24;
    localparam int B_SRC_HI = B_SRC_LO + 1;
    // enable, enable-mode and the four power/debug bits 21:18
    localparam logic [CTRL_W-1:0] SWR_KEEP = 26'h03C_0003;

    typedef enum logic [2:0] {
        A_CTRL = 3'd0,
        A_STAT = 3'd1,
        A_LOAD = 3'd2,
        A_CMP  = 3'd3,
        A_CNT  = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'b00,
        SRC_MAIN = 2'b01,
        SRC_FAST = 2'b10,
        SRC_SLOW = 2'b11
    } src_e;

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_e;
endpackage

// File: rtl/dt_tick_div.sv
`timescale 1ns/1ps
module dt_tick_div
    import dt_pkg::*;
#(
    parameter int DIV_W = PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  src_e             src,
    input  logic             tick_main,
    input  logic             tick_fast,
    input  logic             tick_slow,
    input  logic [DIV_W-1:0] div,
    output logic             step
);
    logic             sel;
    logic [DIV_W-1:0] pcnt_q;
    logic             at_end;

    always_comb begin
        unique case (src)
            SRC_OFF:  sel = 1'b0;
            SRC_MAIN: sel = tick_main;
            SRC_FAST: sel = tick_fast;
            SRC_SLOW: sel = tick_slow;
        endcase
    end

    assign at_end = (pcnt_q >= div);
    assign step   = sel && at_end && !clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (clr) begin
            pcnt_q <= '0;
        end else if (sel) begin
            pcnt_q <= at_end ? '0 : pcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dt_count_fsm.sv
`timescale 1ns/1ps
module dt_count_fsm
    import dt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             step,
    input  logic             reload_mode,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             force_en,
    input  logic [CNT_W-1:0] force_val,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             hit
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, nxt_step;
    logic             advance;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // next state: ARM and STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (en)  state_d = ST_COUNT;
            ST_COUNT: if (!en) state_d = ST_HALT;
        endcase
    end

    // outputs of the machine
    always_comb begin
        run      = (state_q == ST_COUNT) && en;
        advance  = run && step;
        nxt_step = (cnt_q == '0) ? (reload_mode ? load_val : ALL_ONES)
                                 : cnt_q - 1'b1;
        hit      = advance && !force_en && (nxt_step == cmp_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= ALL_ONES;
        else if (force_en) cnt_q <= force_val;
        else if (advance)  cnt_q <= nxt_step;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/dt_timer_top.sv
`timescale 1ns/1ps
module dt_timer_top
    import dt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [2:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        tick_main,
    input  logic        tick_fast,
    input  logic        tick_slow,
    output logic        irq
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CTRL_W-1:0] ctrl_q, ctrl_wr;
    logic [CNT_W-1:0]  load_q, cmp_q, cnt_q, force_val;
    logic              flag_q, force_en, hit, run, step;
    logic              wr_ctrl, wr_stat, wr_load, wr_cmp, swr, en_rise;

    // write decode and counter force selection
    always_comb begin
        wr_ctrl = wr_en && (addr == A_CTRL);
        wr_stat = wr_en && (addr == A_STAT);
        wr_load = wr_en && (addr == A_LOAD);
        wr_cmp  = wr_en && (addr == A_CMP);
        swr     = wr_ctrl && wdata[B_SWR];
        ctrl_wr = wdata[CTRL_W-1:0];
        ctrl_wr[B_SWR] = 1'b0;
        if (wdata[B_SWR]) ctrl_wr = wdata[CTRL_W-1:0] & SWR_KEEP;
        en_rise   = wr_ctrl && ctrl_wr[B_EN] && !ctrl_q[B_EN];
        force_en  = 1'b0;
        force_val = ALL_ONES;
        if (swr) begin
            force_en = 1'b1;
        end else if (en_rise && ctrl_wr[B_ENMOD]) begin
            force_en  = 1'b1;
            force_val = ctrl_wr[B_RLD] ? load_q : ALL_ONES;
        end else if (wr_load && ctrl_q[B_OVW]) begin
            force_en  = 1'b1;
            force_val = wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            load_q <= ALL_ONES;
            cmp_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_wr;
            if (swr) begin
                load_q <= ALL_ONES;
                cmp_q  <= '0;
                flag_q <= 1'b0;
            end else begin
                if (wr_load) load_q <= wdata[CNT_W-1:0];
                if (wr_cmp)  cmp_q  <= wdata[CNT_W-1:0];
                if (hit)                      flag_q <= 1'b1;
                else if (wr_stat && wdata[0]) flag_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (addr)
                A_CTRL:  rdata <= 32'(ctrl_q);
                A_STAT:  rdata <= {31'd0, flag_q};
                A_LOAD:  rdata <= 32'(load_q);
                A_CMP:   rdata <= 32'(cmp_q);
                A_CNT:   rdata <= 32'(cnt_q);
                default: rdata <= '0;
            endcase
        end
    end

    assign irq = flag_q && ctrl_q[B_OCIE] && ctrl_q[B_EN];

    dt_tick_div #(.DIV_W(PRE_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (!run),
        .src       (src_e'(ctrl_q[B_SRC_HI:B_SRC_LO])),
        .tick_main (tick_main),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow),
        .div       (ctrl_q[B_PRE_HI:B_PRE_LO]),
        .step      (step)
    );

    dt_count_fsm #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (ctrl_q[B_EN]),
        .step        (step),
        .reload_mode (ctrl_q[B_RLD]),
        .load_val    (load_q),
        .cmp_val     (cmp_q),
        .force_en    (force_en),
        .force_val   (force_val),
        .cnt         (cnt_q),
        .run         (run),
        .hit         (hit)
    );
endmodule

// File: rtl/dt_timer_chk.sv
`timescale 1ns/1ps
module dt_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             ctrl_en,
    input logic             ctrl_rld,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] load,
    input logic             flag,
    input logic             irq
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    p_hold_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !wr_en) |=> $stable(cnt));

    p_step_by_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && cnt != '0) |=> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) - 1'b1)));

    p_zero_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && cnt == '0 && ctrl_rld) |=> (cnt == '0 || cnt == $past(load)));

    p_zero_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && cnt == '0 && !ctrl_rld) |=> (cnt == '0 || cnt == ALL_ONES));

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !wr_en) |=> flag);

    p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en || !flag) |-> !irq);
endmodule

bind dt_timer_top dt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .ctrl_en  (ctrl_q[0]),
    .ctrl_rld (ctrl_q[3]),
    .cnt      (cnt_q),
    .load     (load_q),
    .flag     (flag_q),
    .irq      (irq)
);

// File: tb/sim_dt_timer_top.sv
`timescale 1ns/1ps
module sim_dt_timer_top;
    localparam logic [31:0] EN = 32'h1, ENMOD = 32'h2, OCIE = 32'h4, RLD = 32'h8;
    localparam logic [31:0] SWR = 32'h1_0000, OVW = 32'h2_0000, PWR = 32'h3C_0000;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic        tick_main = 1'b0, tick_fast = 1'b0, tick_slow = 1'b0, irq;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    dt_timer_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick_main(tick_main), .tick_fast(tick_fast),
        .tick_slow(tick_slow), .irq(irq)
    );

    function automatic logic [31:0] pre(input int p);
        return 32'(p) << 4;
    endfunction
    function automatic logic [31:0] src(input int s);
        return 32'(s) << 24;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = 3'(a); wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = 3'(a);
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic rchk(input string req, input int a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic pulse(input logic [2:0] m);
        @(negedge clk); {tick_slow, tick_fast, tick_main} = m;
        @(negedge clk); {tick_slow, tick_fast, tick_main} = 3'b000;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] m;
        logic        mf;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset values
        rchk("R1 ctrl", 0, 0);
        rchk("R1 status", 1, 0);
        rchk("R1 load", 2, ONES);
        rchk("R1 cmp", 3, 0);
        rchk("R1 count", 4, ONES);
        chk("R1 irq", 32'(irq), 0);
        // R2 control masking and unused addresses
        wr(0, 32'hFF00_0000);
        rchk("R2 upper bits", 0, 32'h0300_0000);
        rchk("R2 addr 5", 5, 0);
        wr(0, 0);
        // R5 R9 R10 reload sweep
        wr(2, 5); wr(3, 2);
        wr(0, EN | ENMOD | RLD | OCIE | src(1));
        idle(2);
        rchk("R7 load on enable", 4, 5);
        m = 5; mf = 1'b0;
        for (int i = 0; i < 14; i++) begin
            pulse(3'b001);
            m = (m == 0) ? 5 : m - 1;
            if (m == 2) mf = 1'b1;
            rchk("R5 reload count", 4, m);
            rchk("R9 flag", 1, 32'(mf));
            chk("R10 irq", 32'(irq), 32'(mf));
        end
        wr(1, 0);
        rchk("R9 write 0 ignored", 1, 1);
        wr(1, 1);
        rchk("R9 clear", 1, 0);
        chk("R10 irq after clear", 32'(irq), 0);
        // R4 prescale sweep
        for (int p = 0; p < 4; p++) begin
            wr(0, ENMOD | RLD | src(1));
            wr(0, EN | ENMOD | RLD | src(1) | pre(p));
            idle(2);
            m = 5;
            for (int k = 1; k <= 2 * (p + 1) + 1; k++) begin
                pulse(3'b001);
                if (k % (p + 1) == 0) m = m - 1;
                rchk("R4 prescale", 4, m);
            end
        end
        // R3 source select
        for (int s = 0; s < 4; s++) begin
            wr(0, ENMOD | RLD | src(1));
            wr(0, EN | ENMOD | RLD | src(s));
            idle(2);
            m = 5;
            for (int t = 1; t < 4; t++) begin
                pulse(3'(1 << (t - 1)));
                if (s == t) m = m - 1;
                rchk("R3 source", 4, m);
            end
        end
        // R6 R7 R8 free-running and overwrite
        wr(0, ENMOD | src(1));
        wr(0, EN | ENMOD | src(1));
        idle(2);
        rchk("R7 free enable loads ones", 4, ONES);
        pulse(3'b001);
        rchk("R6 free step", 4, 32'hFFFF_FFFE);
        wr(0, EN | ENMOD | OVW | src(1));
        wr(2, 1);
        rchk("R8 overwrite", 4, 1);
        pulse(3'b001);
        rchk("R6 to zero", 4, 0);
        pulse(3'b001);
        rchk("R6 wrap", 4, ONES);
        wr(0, EN | ENMOD | OVW | RLD | src(1));
        wr(2, 2);
        rchk("R8 overwrite reload", 4, 2);
        wr(0, EN | ENMOD | RLD | src(1));
        wr(2, 4);
        rchk("R8 no overwrite", 4, 2);
        pulse(3'b001); pulse(3'b001);
        rchk("R8 reached zero", 4, 0);
        pulse(3'b001);
        rchk("R8 new load used", 4, 4);
        // R10 R11 R7 enable gating
        wr(1, 1);
        wr(0, ENMOD | RLD | OCIE | src(1));
        wr(0, EN | ENMOD | RLD | OCIE | src(1));
        idle(2);
        pulse(3'b001); pulse(3'b001);
        rchk("R9 hit", 1, 1);
        chk("R10 irq on", 32'(irq), 1);
        wr(0, RLD | OCIE | src(1));
        chk("R10 irq needs enable", 32'(irq), 0);
        pulse(3'b001); pulse(3'b001); pulse(3'b001);
        rchk("R11 held", 4, 2);
        rchk("R11 flag kept", 1, 1);
        wr(0, EN | RLD | OCIE | src(1));
        idle(2);
        rchk("R7 resume", 4, 2);
        chk("R10 irq back", 32'(irq), 1);
        pulse(3'b001);
        rchk("R7 resume step", 4, 1);
        wr(0, EN | RLD | src(1));
        chk("R10 irq needs ocie", 32'(irq), 0);
        // R12 software reset
        wr(3, 7);
        wr(0, EN | ENMOD | RLD | OCIE | OVW | PWR | pre(3) | src(2));
        wr(0, SWR | EN | ENMOD | RLD | OCIE | OVW | PWR | pre(5) | src(1));
        rchk("R12 ctrl kept", 0, EN | ENMOD | PWR);
        rchk("R12 status", 1, 0);
        rchk("R12 cmp", 3, 0);
        rchk("R12 load", 2, ONES);
        rchk("R12 count", 4, ONES);
        chk("R12 irq", 32'(irq), 0);
        pulse(3'b111);
        rchk("R3 source off", 4, ONES);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule